// File: doc/BRIEF.md
# CAN identifier screen

This block sits beside a CAN receiver and watches the first eleven arbitration bits of every frame as they arrive, one bit per strobe, in bus order. As soon as the eleventh bit has been sampled, it makes two independent decisions on those bits. The first is an acceptance decision against a programmable mask and code. Frames that fail it must not be handed to software. The second is an exact comparison against a programmable trigger pattern. A hit produces a one-clock pulse, which can restart an external supervision timer without any processor involvement.

A start-of-frame strobe re-arms both decisions. Bits beyond the eleventh, as in extended frames, are ignored. Frames the node sends itself bypass the filter. At the end of a good frame the receiver raises a frame-ok strobe. The block converts that strobe into a commit pulse only for frames that were accepted, and the commit pulse is what lets the receive buffer and its done flag update.

Top module: `can_id_screen`

## Requirements
- R1: While reset is asserted and after its release, decided_o, accept_o, trig_o and rx_commit_o are all 0 until a frame supplies eleven bits.
- R2: Identifier bits are numbered in arrival order: the first bit strobed after start of frame is identifier bit 0, so it is compared with bit 0 of the mask, code and pattern fields.
- R3: A received frame is accepted when ((ID AND mask) XOR code) is zero over all 11 bits. The mask is filt_cfg_i[10:0] and the code is filt_cfg_i[26:16]. filt_cfg_i bits 15:11 and 31:27 have no effect, and a code bit of 1 under a mask bit of 0 always rejects.
- R4: decided_o and accept_o change only at the clock edge that samples the eleventh bit. Both are therefore visible in the cycle after that edge, and decided_o is still 0 after ten bits.
- R5: Strobed bits after the eleventh bit change neither the decision nor the trigger, so extended frames are judged on their first eleven bits only.
- R6: trig_o is high for exactly one clock, at the same edge that sets decided_o, when the eleven bits equal trig_cfg_i[10:0]. Bits 31:11 of trig_cfg_i have no effect. The trigger is independent of acceptance.
- R7: sof_i clears decided_o and accept_o at the next edge and restarts bit counting. A bit strobed in the same cycle as sof_i is discarded.
- R8: For a frame whose start had own_tx_i high, accept_o is 1 whatever the filter settings.
- R9: frame_ok_i while the current frame is decided and accepted gives a one-clock rx_commit_o at the next edge. For a rejected frame, rx_commit_o stays 0.
- R10: frame_ok_i before the eleventh bit of the current frame gives no rx_commit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of frame strobe, re-arms the decisions |
| own_tx_i | input | 1 | Sampled at sof_i: the frame is sent by this node |
| bit_vld_i | input | 1 | Strobe, one arbitration bit present on bit_i |
| bit_i | input | 1 | Arbitration bit value |
| frame_ok_i | input | 1 | Receiver reports a complete, error-free frame |
| filt_cfg_i | input | 32 | Mask in [10:0], code in [26:16] |
| trig_cfg_i | input | 32 | Trigger pattern in [10:0] |
| accept_o | output | 1 | Current frame passes the filter (valid when decided_o) |
| decided_o | output | 1 | Eleven bits seen since the last start of frame |
| trig_o | output | 1 | One-clock pulse on a trigger pattern match |
| rx_commit_o | output | 1 | One-clock permission to store the received frame |

## Verification
The filter is tried with a full mask against equal and off-by-one identifiers, with an all-zero mask, and with a partial mask whose code either agrees or disagrees inside the masked nibble. Those cases separate a correct AND-then-XOR from a plain compare or from an inverted mask. A code bit set under a cleared mask shows whether the formula is applied literally. A stream whose only 1 is the first bit distinguishes arrival-order numbering from reversed numbering. Extended-length streams, a restart with a bit strobed in the same cycle as the start, own frames under a rejecting filter, and frame-ok strobes arriving before the decision or on rejected frames each test one of the re-arm and commit rules.

// File: rtl/can_id_screen_pkg.sv
package can_id_screen_pkg;
  localparam int ID_BITS  = 11;
  localparam int CFG_W    = 32;
  localparam int CODE_LSB = 16;
  localparam int CNT_W    = $clog2(ID_BITS + 1);
endpackage

// File: rtl/can_id_collect.sv
module can_id_collect #(
  parameter int ID_W  = can_id_screen_pkg::ID_BITS,
  parameter int CNT_W = can_id_screen_pkg::CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_i,
  input  logic            bit_vld_i,
  input  logic            bit_i,
  output logic [ID_W-1:0] id_next_o,
  output logic            last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             take;
  logic             reg_en;

  // a bit is taken only while the field is incomplete and no restart is pending
  assign take   = bit_vld_i && !sof_i && (cnt_q < CNT_W'(ID_W));
  assign reg_en = sof_i || take;

  // bit k of the field holds the k-th arrived bit
  for (genvar gi = 0; gi < ID_W; gi++) begin : g_slot
    always_comb begin
      if (sof_i)
        id_d[gi] = 1'b0;
      else if (take && (cnt_q == CNT_W'(gi)))
        id_d[gi] = bit_i;
      else
        id_d[gi] = id_q[gi];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (sof_i)
      cnt_d = '0;
    else if (take)
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      id_q  <= '0;
    end else if (reg_en) begin
      cnt_q <= cnt_d;
      id_q  <= id_d;
    end
  end

  assign id_next_o = id_d;
  assign last_o    = take && (cnt_q == CNT_W'(ID_W - 1));

  // counter saturates after the final identifier bit; later bits are dropped
  assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (cnt_q == CNT_W'(ID_W)));
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CNT_W'(ID_W)));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (cnt_q == '0));
endmodule

// File: rtl/can_id_match.sv
module can_id_match #(
  parameter int W = can_id_screen_pkg::ID_BITS
) (
  input  logic [W-1:0] id_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] code_i,
  output logic         hit_o
);
  logic [W-1:0] miss;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign miss[gi] = (id_i[gi] & mask_i[gi]) ^ code_i[gi];
  end

  assign hit_o = ~|miss;
endmodule

// File: rtl/can_id_decide.sv
module can_id_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic sof_i,
  input  logic own_tx_i,
  input  logic last_i,
  input  logic filt_hit_i,
  input  logic trig_hit_i,
  input  logic frame_ok_i,
  output logic decided_o,
  output logic accept_o,
  output logic trig_o,
  output logic commit_o
);
  logic own_q, own_d;
  logic dec_q, dec_d;
  logic acc_q, acc_d;
  logic trg_q, trg_d;
  logic cmt_q, cmt_d;
  logic dec_en;

  assign dec_en = sof_i || last_i;

  always_comb begin
    own_d = own_q;
    dec_d = dec_q;
    acc_d = acc_q;
    if (sof_i) begin
      own_d = own_tx_i;
      dec_d = 1'b0;
      acc_d = 1'b0;
    end else if (last_i) begin
      dec_d = 1'b1;
      acc_d = own_q || filt_hit_i;
    end
    trg_d = last_i && trig_hit_i;
    cmt_d = frame_ok_i && dec_q && acc_q && !sof_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      dec_q <= 1'b0;
      acc_q <= 1'b0;
    end else if (dec_en) begin
      own_q <= own_d;
      dec_q <= dec_d;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q <= 1'b0;
      cmt_q <= 1'b0;
    end else begin
      trg_q <= trg_d;
      cmt_q <= cmt_d;
    end
  end

  assign decided_o = dec_q;
  assign accept_o  = acc_q;
  assign trig_o    = trg_q;
  assign commit_o  = cmt_q;

  assert_trig_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);
  assert_trig_at_decision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (decided_o && $rose(decided_o)));
  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (!decided_o && !accept_o));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decided_o && !sof_i) |=> (decided_o && $stable(accept_o)));
  assert_accept_needs_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> decided_o);
  assert_commit_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(frame_ok_i) && $past(accept_o)));
endmodule

// File: rtl/can_id_screen.sv
module can_id_screen #(
  parameter int ID_W     = can_id_screen_pkg::ID_BITS,
  parameter int CFG_W    = can_id_screen_pkg::CFG_W,
  parameter int CODE_LSB = can_id_screen_pkg::CODE_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             own_tx_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             frame_ok_i,
  input  logic [CFG_W-1:0] filt_cfg_i,
  input  logic [CFG_W-1:0] trig_cfg_i,
  output logic             accept_o,
  output logic             decided_o,
  output logic             trig_o,
  output logic             rx_commit_o
);
  localparam int CNT_W = $clog2(ID_W + 1);

  logic [ID_W-1:0] id_next;
  logic [ID_W-1:0] mask;
  logic [ID_W-1:0] code;
  logic [ID_W-1:0] pattern;
  logic [ID_W-1:0] all_ones;
  logic            last_bit;
  logic            filt_hit;
  logic            trig_hit;
  logic            unused_cfg;

  assign mask     = filt_cfg_i[ID_W-1:0];
  assign code     = filt_cfg_i[CODE_LSB +: ID_W];
  assign pattern  = trig_cfg_i[ID_W-1:0];
  assign all_ones = '1;
  assign unused_cfg = ^{filt_cfg_i[CFG_W-1:CODE_LSB+ID_W],
                        filt_cfg_i[CODE_LSB-1:ID_W],
                        trig_cfg_i[CFG_W-1:ID_W]};

  can_id_collect #(.ID_W(ID_W), .CNT_W(CNT_W)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_i     (sof_i),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .id_next_o (id_next),
    .last_o    (last_bit)
  );

  can_id_match #(.W(ID_W)) u_filter (
    .id_i   (id_next),
    .mask_i (mask),
    .code_i (code),
    .hit_o  (filt_hit)
  );

  // exact comparison: full mask, pattern as code
  can_id_match #(.W(ID_W)) u_trigger (
    .id_i   (id_next),
    .mask_i (all_ones),
    .code_i (pattern),
    .hit_o  (trig_hit)
  );

  can_id_decide u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_i      (sof_i),
    .own_tx_i   (own_tx_i),
    .last_i     (last_bit),
    .filt_hit_i (filt_hit),
    .trig_hit_i (trig_hit),
    .frame_ok_i (frame_ok_i),
    .decided_o  (decided_o),
    .accept_o   (accept_o),
    .trig_o     (trig_o),
    .commit_o   (rx_commit_o)
  );

  assert_no_commit_undecided_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit_o |-> decided_o);
  assert_decide_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decided_o) |-> $past(bit_vld_i));
endmodule

// File: tb/can_id_screen_bench.sv
module can_id_screen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof_i = 1'b0, own_tx_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, frame_ok_i = 1'b0;
  logic [31:0] filt_cfg_i = '0, trig_cfg_i = '0;
  logic        accept_o, decided_o, trig_o, rx_commit_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_id_screen u_can_id_screen (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .own_tx_i(own_tx_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i), .frame_ok_i(frame_ok_i),
    .filt_cfg_i(filt_cfg_i), .trig_cfg_i(trig_cfg_i),
    .accept_o(accept_o), .decided_o(decided_o), .trig_o(trig_o),
    .rx_commit_o(rx_commit_o)
  );

  // {own, id, mask, code, pattern, extra bits, exp accept, exp trigger}
  localparam logic [51:0] VEC [0:7] = '{
    {1'b0, 11'h123, 11'h7FF, 11'h123, 11'h000, 5'd0,  1'b1, 1'b0},
    {1'b0, 11'h124, 11'h7FF, 11'h123, 11'h124, 5'd0,  1'b0, 1'b1},
    {1'b0, 11'h5A5, 11'h000, 11'h000, 11'h5A5, 5'd18, 1'b1, 1'b1},
    {1'b0, 11'h5A5, 11'h0F0, 11'h0A0, 11'h000, 5'd3,  1'b1, 1'b0},
    {1'b0, 11'h5A5, 11'h0F0, 11'h050, 11'h000, 5'd0,  1'b0, 1'b0},
    {1'b0, 11'h000, 11'h000, 11'h001, 11'h000, 5'd2,  1'b0, 1'b1},
    {1'b1, 11'h124, 11'h7FF, 11'h123, 11'h3FF, 5'd0,  1'b1, 1'b0},
    {1'b0, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF, 5'd7,  1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_frame(input logic own);
    @(negedge clk);
    sof_i = 1'b1; own_tx_i = own; bit_vld_i = 1'b0;
    @(negedge clk);
    sof_i = 1'b0; own_tx_i = 1'b0;
  endtask

  // drives 11 id bits (bit 0 first) plus extra bits; reports trigger pulses and decision
  task automatic push_id(input logic [10:0] id, input int extra,
                         output int trigs, output logic acc_at_dec);
    trigs = 0;
    acc_at_dec = 1'b0;
    for (int k = 0; k < 11; k++) begin
      bit_vld_i = 1'b1; bit_i = id[k];
      @(negedge clk);
      if (trig_o) trigs++;
      if (k == 9) check(decided_o == 1'b0, "R4 undecided after ten bits", decided_o, 0);
      if (k == 10) begin
        check(decided_o == 1'b1, "R4 decided after eleventh bit", decided_o, 1);
        acc_at_dec = accept_o;
      end
    end
    for (int k = 0; k < extra; k++) begin
      bit_vld_i = 1'b1; bit_i = k[0] ^ id[k % 11] ^ 1'b1;
      @(negedge clk);
      if (trig_o) trigs++;
    end
    bit_vld_i = 1'b0;
    @(negedge clk);
    if (trig_o) trigs++;
  endtask

  task automatic end_frame(input logic exp_commit, input string req);
    frame_ok_i = 1'b1;
    @(negedge clk);
    frame_ok_i = 1'b0;
    check(rx_commit_o == exp_commit, req, rx_commit_o, exp_commit);
    @(negedge clk);
    check(rx_commit_o == 1'b0, "R9 commit lasts one clock", rx_commit_o, 0);
  endtask

  initial begin
    int trigs;
    logic acc;
    repeat (3) @(negedge clk);
    check({accept_o, decided_o, trig_o, rx_commit_o} == 4'b0, "R1 outputs in reset",
          {accept_o, decided_o, trig_o, rx_commit_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({accept_o, decided_o, trig_o, rx_commit_o} == 4'b0, "R1 outputs after reset",
          {accept_o, decided_o, trig_o, rx_commit_o}, 0);

    // table walk: R3 filter, R6 trigger, R5 extended, R8 own frames, R9 commit
    for (int v = 0; v < 8; v++) begin
      logic [51:0] e;
      e = VEC[v];
      filt_cfg_i = {5'h00, e[28:18], 5'h00, e[39:29]};
      trig_cfg_i = {21'h0, e[17:7]};
      start_frame(e[51]);
      push_id(e[50:40], int'(e[6:2]), trigs, acc);
      check(acc == e[1], e[51] ? "R8 own frame accepted" : "R3 accept decision", acc, e[1]);
      check(trigs == int'(e[0]), "R6 trigger pulse count", trigs, e[0]);
      check(accept_o == e[1] && decided_o, "R5 decision held after later bits", accept_o, e[1]);
      end_frame(e[1], "R9 commit follows acceptance");
    end

    // R3: reserved config bits set have no effect (vector 4 stays rejected, pattern unaffected)
    filt_cfg_i = {5'h1F, 11'h050, 5'h1F, 11'h0F0};
    trig_cfg_i = {21'h1FFFFF, 11'h5A5};
    start_frame(1'b0);
    push_id(11'h5A5, 0, trigs, acc);
    check(acc == 1'b0, "R3 reserved filter bits ignored", acc, 0);
    check(trigs == 1, "R6 reserved trigger bits ignored", trigs, 1);

    // R2: only the first arrived bit is 1
    filt_cfg_i = {5'h0, 11'h001, 5'h0, 11'h7FF};
    trig_cfg_i = {21'h0, 11'h001};
    start_frame(1'b0);
    push_id(11'h001, 0, trigs, acc);
    check(acc == 1'b1, "R2 first bit maps to field bit 0 (filter)", acc, 1);
    check(trigs == 1, "R2 first bit maps to field bit 0 (trigger)", trigs, 1);
    trig_cfg_i = {21'h0, 11'h400};
    start_frame(1'b0);
    push_id(11'h001, 0, trigs, acc);
    check(trigs == 0, "R2 reversed order must not trigger", trigs, 0);

    // R7: restart mid-field, bit strobed together with sof is dropped
    filt_cfg_i = {5'h0, 11'h000, 5'h0, 11'h7FF};
    trig_cfg_i = {21'h0, 11'h000};
    start_frame(1'b0);
    for (int k = 0; k < 5; k++) begin
      bit_vld_i = 1'b1; bit_i = 1'b1;
      @(negedge clk);
    end
    sof_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0; bit_vld_i = 1'b0;
    check(decided_o == 1'b0, "R7 restart leaves frame undecided", decided_o, 0);
    push_id(11'h000, 0, trigs, acc);
    check(acc == 1'b1, "R7 bit with sof discarded (filter)", acc, 1);
    check(trigs == 1, "R7 bit with sof discarded (trigger)", trigs, 1);
    // R7: a later sof clears a standing decision
    start_frame(1'b0);
    check(decided_o == 1'b0 && accept_o == 1'b0, "R7 sof clears decision",
          {decided_o, accept_o}, 0);

    // R10: frame_ok before the eleventh bit
    for (int k = 0; k < 4; k++) begin
      bit_vld_i = 1'b1; bit_i = 1'b0;
      @(negedge clk);
    end
    bit_vld_i = 1'b0;
    end_frame(1'b0, "R10 no commit before decision");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule